// File: doc/BRIEF.md
# Paired Set/Clear GPIO Register

This block is one 32-bit register on a simple synchronous register bus that owns up to eight general-purpose pins. It holds no plain data bits. Every write carries action bits only: within the low half, each pin has a pair that sets or clears its output latch. Within the high half, each pin has a pair that turns its driver on (output) or off (input). A 1 in an action bit performs the action and a 0 does nothing. Software can therefore change one pin with a single write and does not have to read, modify and write back the whole register.

A read returns live status in the same bit positions. What a pin reports depends on its direction. An output pin reports its driven level and its enable flag. An input pin reports its sampled level, after a two-flop synchronizer. A toggle is a read followed by one write: if the pin's low status bit is 1, write its clear action, otherwise write its set action. Two instances placed side by side cover twelve pins, with the second built for four pins.

Top module: `gpio_pair_reg`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0), every output latch is 0 (`pin_out` = 0), and a selected read returns 0 while all pins are low.
- R2: A write with bit 2n+1 = 1 and bit 2n = 0 sets the output latch of pin n, and `pin_out[n]` shows the new value from the clock edge that takes the write. Bit 2n = 1 with bit 2n+1 = 0 clears the latch in the same way.
- R3: A write with bit 16+2n = 1 and bit 17+2n = 0 makes pin n an output (`pin_oe[n]` = 1). Bit 17+2n = 1 with bit 16+2n = 0 makes pin n an input.
- R4: An action bit written as 0 has no effect, so pins whose pair bits are both 0 keep their level and direction.
- R5: If both bits of a pair are 1 in the same write, that pair is ignored for that pin. Other pins in the same write are still updated.
- R6: While pin n is an output, a read returns 1 at bit 16+2n, the latch level at bit 2n, and 0 at bits 2n+1 and 17+2n.
- R7: While pin n is an input, a read returns the pin level at bit 2n+1 and 0 at bits 2n, 16+2n and 17+2n. A change on `pin_in[n]` reaches the readback on the second rising clock edge after the change and not before.
- R8: The output latch keeps its value while the pin is an input. `pin_out[n]` always shows the latch, and the latch is driven again as soon as the pin is made an output.
- R9: A write happens only when `sel` and `wr_en` are both 1 at a clock edge. In all other cycles `pin_out` and `pin_oe` keep their values.
- R10: When `sel` is 0, `rdata` is 0.
- R11: Pin slots at or above `PIN_CNT` are not populated. Their `pin_out`, `pin_oe` and readback bits stay 0 whatever is written or applied to `pin_in`.
- R12: The toggle sequence (read bit 2n, then write the clear action if it was 1, otherwise the set action) inverts the level of an output pin each time it is run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe, effective with `sel` |
| wdata | input | 32 | Action bits: set/clear pairs in bits 15:0, enable/disable pairs in bits 31:16 |
| rdata | output | 32 | Live status, zero when not selected |
| pin_in | input | 8 | Sampled pin levels (asynchronous) |
| pin_out | output | 8 | Output latch per pin |
| pin_oe | output | 8 | Output enable per pin |

## Verification
The case that is hardest to reach from the ports is one write in which some pairs act, some are all-zero and some carry both bits at once, spread across both halves. It has to be followed by a check that every other pin kept both its level and its direction. The stimulus table builds up state step by step with writes that mix these three kinds of pair, including a conflicting pair in one half next to a real action in the other half. After each write it checks all eight levels, all eight enables and the full readback. Directed steps then hold a pin as an input while its latch is changed, and check the synchronizer delay one edge at a time. They also run the read-then-write toggle and drive a four-pin instance with writes aimed at its empty slots.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;

   localparam int unsigned REG_W    = 32;
   localparam int unsigned HALF_W   = REG_W / 2;
   localparam int unsigned SLOT_MAX = HALF_W / 2;

   // one action pair as seen on the bus: [1] is the odd bit, [0] the even bit
   typedef struct packed {
      logic odd;
      logic even;
   } act_pair_t;

   // a pair acts only when exactly one of its bits is written as one
   function automatic logic pair_valid(input act_pair_t p);
      return p.odd ^ p.even;
   endfunction

endpackage

// File: rtl/gpio_pair_sync.sv
module gpio_pair_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_pair_lane.sv
module gpio_pair_lane
   import gpio_pair_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_go,
   input  act_pair_t lvl_act,   // odd = set, even = clear
   input  act_pair_t dir_act,   // odd = disable, even = enable
   input  logic      pin_sync,
   output logic      lvl,
   output logic      oe,
   output act_pair_t rd_lvl,
   output act_pair_t rd_dir
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl <= 1'b0;
         oe  <= 1'b0;
      end else if (wr_go) begin
         if (pair_valid(lvl_act)) lvl <= lvl_act.odd;
         if (pair_valid(dir_act)) oe  <= dir_act.even;
      end
   end

   always_comb begin
      if (oe) begin
         rd_lvl.even = lvl;
         rd_lvl.odd  = 1'b0;
      end else begin
         rd_lvl.even = 1'b0;
         rd_lvl.odd  = pin_sync;
      end
      rd_dir.even = oe;
      rd_dir.odd  = 1'b0;
   end

endmodule

// File: rtl/gpio_pair_reg.sv
module gpio_pair_reg
   import gpio_pair_pkg::*;
#(
   parameter int unsigned PIN_CNT     = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel,
   input  logic                wr_en,
   input  logic [REG_W-1:0]    wdata,
   output logic [REG_W-1:0]    rdata,
   input  logic [SLOT_MAX-1:0] pin_in,
   output logic [SLOT_MAX-1:0] pin_out,
   output logic [SLOT_MAX-1:0] pin_oe
);

   if (PIN_CNT < 1 || PIN_CNT > SLOT_MAX) begin : g_bad_pin_cnt
      $error("gpio_pair_reg: PIN_CNT must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_pair_reg: SYNC_STAGES must be at least 2");
   end

   logic                wr_go;
   logic [SLOT_MAX-1:0] pin_sync;
   logic [REG_W-1:0]    status;

   assign wr_go = sel & wr_en;

   gpio_pair_sync #(
      .WIDTH  (SLOT_MAX),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   for (genvar n = 0; n < SLOT_MAX; n++) begin : g_slot
      if (n < PIN_CNT) begin : g_live
         act_pair_t rd_lvl, rd_dir;

         gpio_pair_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_go    (wr_go),
            .lvl_act  (act_pair_t'(wdata[2*n+1 -: 2])),
            .dir_act  (act_pair_t'(wdata[HALF_W+2*n+1 -: 2])),
            .pin_sync (pin_sync[n]),
            .lvl      (pin_out[n]),
            .oe       (pin_oe[n]),
            .rd_lvl   (rd_lvl),
            .rd_dir   (rd_dir)
         );

         assign status[2*n+1 -: 2]        = rd_lvl;
         assign status[HALF_W+2*n+1 -: 2] = rd_dir;
      end else begin : g_empty
         logic unused_slot;
         assign unused_slot = ^{pin_sync[n], wdata[2*n+1 -: 2],
                                wdata[HALF_W+2*n+1 -: 2]};
         assign pin_out[n]                = 1'b0;
         assign pin_oe[n]                 = 1'b0;
         assign status[2*n+1 -: 2]        = 2'b00;
         assign status[HALF_W+2*n+1 -: 2] = 2'b00;
      end
   end

   assign rdata = sel ? status : '0;

endmodule

// File: rtl/gpio_pair_reg_chk.sv
module gpio_pair_reg_chk
   import gpio_pair_pkg::*;
#(
   parameter int unsigned PIN_CNT = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sel,
   input logic                wr_en,
   input logic [REG_W-1:0]    wdata,
   input logic [REG_W-1:0]    rdata,
   input logic [SLOT_MAX-1:0] pin_out,
   input logic [SLOT_MAX-1:0] pin_oe
);

   p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> rdata == '0);

   for (genvar n = 0; n < SLOT_MAX; n++) begin : g_pin
      if (n < PIN_CNT) begin : g_live
         p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && wr_en && wdata[2*n+1] && !wdata[2*n]) |=> pin_out[n]);
         p_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && wr_en && wdata[2*n] && !wdata[2*n+1]) |=> !pin_out[n]);
         p_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && wr_en && wdata[HALF_W+2*n] && !wdata[HALF_W+2*n+1]) |=> pin_oe[n]);
         p_dis_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && wr_en && wdata[HALF_W+2*n+1] && !wdata[HALF_W+2*n]) |=> !pin_oe[n]);
         p_conflict_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && wr_en && wdata[2*n] && wdata[2*n+1]) |=> $stable(pin_out[n]));
         p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(sel && wr_en) |=> $stable(pin_out[n]) && $stable(pin_oe[n]));
         p_out_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && pin_oe[n]) |-> (rdata[2*n+1 -: 2] == {1'b0, pin_out[n]}) &&
                                   (rdata[HALF_W+2*n+1 -: 2] == 2'b01));
         p_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && !pin_oe[n]) |-> !rdata[2*n] && (rdata[HALF_W+2*n+1 -: 2] == 2'b00));
      end else begin : g_empty
         p_empty_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_out[n] && !pin_oe[n] && (rdata[2*n+1 -: 2] == 2'b00) &&
            (rdata[HALF_W+2*n+1 -: 2] == 2'b00));
      end
   end

endmodule

bind gpio_pair_reg gpio_pair_reg_chk #(.PIN_CNT(PIN_CNT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel     (sel),
   .wr_en   (wr_en),
   .wdata   (wdata),
   .rdata   (rdata),
   .pin_out (pin_out),
   .pin_oe  (pin_oe)
);

// File: tb/gpio_pair_reg_tb.sv
`timescale 1ns/1ps
module gpio_pair_reg_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [7:0]  pin_in = '0;
   logic [31:0] rdata, rdata_n;
   logic [7:0]  pin_out, pin_oe, pin_out_n, pin_oe_n;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   gpio_pair_reg u_dut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

   gpio_pair_reg #(.PIN_CNT(4)) u_dut_narrow (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata_n), .pin_in(pin_in), .pin_out(pin_out_n), .pin_oe(pin_oe_n));

   // {wdata, expected pin_out, expected pin_oe}, cumulative from reset
   localparam int NVEC = 10;
   localparam logic [47:0] VEC [NVEC] = '{
      {32'h0000_0002, 8'h01, 8'h00},   // R2 set pin0
      {32'h0001_0000, 8'h01, 8'h01},   // R3 enable pin0
      {32'hAAAA_5555, 8'h00, 8'h00},   // R2 R3 clear all, disable all
      {32'h5555_AAAA, 8'hFF, 8'hFF},   // R2 R3 set all, enable all
      {32'h0000_0000, 8'hFF, 8'hFF},   // R4 zeros do nothing
      {32'h0000_0003, 8'hFF, 8'hFF},   // R5 conflicting level pair
      {32'h000C_0004, 8'hFD, 8'hFF},   // R5 R4 conflict on dir, clear pin1
      {32'h8000_4000, 8'h7D, 8'h7F},   // R3 disable pin7, clear pin7
      {32'h0000_8001, 8'hFC, 8'h7F},   // R8 set pin7 as input, clear pin0
      {32'h0003_0000, 8'hFC, 8'h7F}    // R5 conflicting direction pair
   };

   function automatic logic [31:0] exp_rd(input logic [7:0] o, input logic [7:0] e,
                                         input logic [7:0] p, input logic [7:0] m);
      logic [31:0] r = '0;
      for (int n = 0; n < 8; n++) begin
         if (m[n]) begin
            if (e[n]) begin
               r[16+2*n] = 1'b1;
               r[2*n]    = o[n];
            end else begin
               r[2*n+1]  = p[n];
            end
         end
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, tag, act, exp);
   endtask

   task automatic bus_write(input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr_en = 1'b1; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic toggle_pin(input int n);
      logic [31:0] d;
      @(negedge clk);
      sel = 1'b1; wr_en = 1'b0;
      d = rdata[2*n] ? (32'h1 << (2*n)) : (32'h1 << (2*n+1));
      bus_write(d);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] eo, ee;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      sel   = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_eq("R1 pin_out", {24'h0, pin_out}, 32'h0);
      chk_eq("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
      chk_eq("R1 rdata", rdata, 32'h0);
      chk_eq("R1 narrow rdata", rdata_n, 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         bus_write(VEC[i][47:16]);
         eo = VEC[i][15:8];
         ee = VEC[i][7:0];
         chk_eq($sformatf("R2 R4 R5 vec%0d pin_out", i), {24'h0, pin_out}, {24'h0, eo});
         chk_eq($sformatf("R3 R4 R5 vec%0d pin_oe", i), {24'h0, pin_oe}, {24'h0, ee});
         chk_eq($sformatf("R6 R7 vec%0d rdata", i), rdata, exp_rd(eo, ee, 8'h00, 8'hFF));
         chk_eq($sformatf("R11 vec%0d narrow pin_out", i), {24'h0, pin_out_n}, {24'h0, eo & 8'h0F});
         chk_eq($sformatf("R11 vec%0d narrow rdata", i), rdata_n,
                exp_rd(eo, ee, 8'h00, 8'h0F));
      end

      // R10 unselected read
      @(negedge clk);
      sel = 1'b0;
      #1;
      chk_eq("R10 rdata idle", rdata, 32'h0);
      chk_eq("R10 narrow rdata idle", rdata_n, 32'h0);

      // R9 strobe without select, select without strobe
      wr_en = 1'b1; wdata = 32'h5555_AAAA;
      @(negedge clk);
      chk_eq("R9 no sel pin_out", {24'h0, pin_out}, 32'hFC);
      chk_eq("R9 no sel pin_oe", {24'h0, pin_oe}, 32'h7F);
      sel = 1'b1; wr_en = 1'b0;
      @(negedge clk);
      chk_eq("R9 no strobe pin_out", {24'h0, pin_out}, 32'hFC);
      chk_eq("R9 no strobe pin_oe", {24'h0, pin_oe}, 32'h7F);
      wdata = '0;

      // R7 all inputs, synchronizer delay
      bus_write(32'hAAAA_0000);
      pin_in = 8'hA5;
      @(negedge clk);
      chk_eq("R7 one edge not yet", rdata, exp_rd(8'hFC, 8'h00, 8'h00, 8'hFF));
      @(negedge clk);
      chk_eq("R7 two edges visible", rdata, exp_rd(8'hFC, 8'h00, 8'hA5, 8'hFF));
      chk_eq("R7 narrow input", rdata_n, exp_rd(8'hFC, 8'h00, 8'hA5, 8'h0F));
      // R8 latch held while input, changed while input
      chk_eq("R8 latch kept", {24'h0, pin_out}, 32'hFC);
      bus_write(32'h0000_0002);
      chk_eq("R8 latch set as input", {24'h0, pin_out}, 32'hFD);
      chk_eq("R8 input readback", rdata, exp_rd(8'hFD, 8'h00, 8'hA5, 8'hFF));
      bus_write(32'h5555_0000);
      chk_eq("R8 driven on enable", rdata, exp_rd(8'hFD, 8'hFF, 8'hA5, 8'hFF));

      // R12 toggle sequence
      toggle_pin(3);
      chk_eq("R12 toggle pin3 down", {24'h0, pin_out}, 32'hF5);
      toggle_pin(3);
      chk_eq("R12 toggle pin3 up", {24'h0, pin_out}, 32'hFD);
      toggle_pin(1);
      chk_eq("R12 toggle pin1 up", {24'h0, pin_out}, 32'hFF);
      toggle_pin(0);
      chk_eq("R12 toggle pin0 down", {24'h0, pin_out}, 32'hFE);

      // R11 empty slots on the narrow instance
      pin_in = 8'hFF;
      bus_write(32'hAAAA_5555);
      bus_write(32'h5555_AAAA);
      chk_eq("R11 narrow outputs", {16'h0, pin_oe_n, pin_out_n}, 32'h0F0F);
      chk_eq("R11 narrow read out", rdata_n, 32'h0055_0055);
      bus_write(32'hAAAA_0000);
      @(negedge clk);
      chk_eq("R11 narrow read in", rdata_n, 32'h0000_00AA);
      chk_eq("R7 wide read in", rdata, 32'h0000_AAAA);

      finish_run();
   end

endmodule